// File: doc/BRIEF.md
# Agree-Mode Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. A shift register records the outcomes of the most recently resolved branches. That history is XORed with low-order bits of the branch address to select one entry in a table of two-bit saturating counters. A counter does not say "taken" or "not taken". It says whether the branch is expected to agree with a static guess. The static guess is either a hint supplied by the front end or, when no hint is given, a direction heuristic: backward branches are taken and forward branches are not.

A fetch stage presents the branch address, its target and an optional hint. It receives the direction, the static guess and the table index that was used, all combinationally in the same cycle. When the branch resolves, the back end returns the actual outcome together with the index and static guess it captured at prediction time. The counter at that index is trained, and the outcome is shifted into the history on the next clock edge.

Top module: `agree_gshare_pred`

## Requirements
- R1: After reset every counter holds 2'b10 (weak agree) and the history is all zeros, so every prediction equals its static guess until training changes it.
- R2: On each clock edge with `upd_vld` high, the history shifts left by one and `upd_taken` enters bit 0. With `upd_vld` low, the history is unchanged.
- R3: `pred_idx` equals `pred_pc[HIST_W+1:2]` XOR the current history.
- R4: On update, the addressed counter increments when `upd_taken` equals `upd_static` and decrements otherwise, saturating at 3 and at 0.
- R5: `pred_static` equals `pred_hint` when `pred_hint_vld` is 1. Otherwise it is 1 exactly when `pred_target` is below `pred_pc` (unsigned compare).
- R6: `pred_dir` equals `pred_static` when bit 1 of the indexed counter is 1, and its inverse when that bit is 0.
- R7: Training addresses the entry given by `upd_idx` and ignores the current history and address, so a stale captured index still trains the entry that made the prediction.
- R8: Prediction outputs depend combinationally on the present inputs and state. An update becomes visible only after the next rising edge, so a prediction in the same cycle as an update sees the old counter and history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_target | input | PC_W | Branch target, used by the heuristic |
| pred_hint_vld | input | 1 | A static hint is supplied |
| pred_hint | input | 1 | Static hint: 1 taken |
| pred_dir | output | 1 | Predicted direction, 1 taken |
| pred_static | output | 1 | Static guess used for this prediction |
| pred_idx | output | HIST_W | Table index used; to be returned on update |
| upd_vld | input | 1 | A resolved branch is reported |
| upd_idx | input | HIST_W | Index captured at prediction time |
| upd_static | input | 1 | Static guess captured at prediction time |
| upd_taken | input | 1 | Actual outcome, 1 taken |

## Verification
The three prediction outputs are due in the same cycle as the address, target and hint that produce them. The bench drives those inputs just after a falling edge and samples the outputs one time step later, before the next rising edge. Counter and history changes from an update are due one rising edge after the update is presented. The behavioural model therefore applies each update at that edge, and the next falling-edge comparison is the first to expect the new state. The bench includes a same-cycle predict-and-update pattern, which confirms that the prediction sees the state from before that edge.

// File: rtl/agree_gshare_pred.sv
module agree_gshare_pred #(
  parameter int HIST_W = 10,
  parameter int PC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   pred_pc,
  input  logic [PC_W-1:0]   pred_target,
  input  logic              pred_hint_vld,
  input  logic              pred_hint,
  output logic              pred_dir,
  output logic              pred_static,
  output logic [HIST_W-1:0] pred_idx,
  input  logic              upd_vld,
  input  logic [HIST_W-1:0] upd_idx,
  input  logic              upd_static,
  input  logic              upd_taken
);
  localparam int ENTRIES = 1 << HIST_W;

  logic [HIST_W-1:0] hist;
  logic [1:0]        tbl [ENTRIES];
  logic [1:0]        cur;
  logic              agree;

  assign pred_idx    = pred_pc[HIST_W+1:2] ^ hist;
  assign pred_static = pred_hint_vld ? pred_hint : (pred_target < pred_pc);
  assign cur         = tbl[pred_idx];
  assign pred_dir    = cur[1] ? pred_static : ~pred_static;
  assign agree       = (upd_taken == upd_static);

  always_ff @(posedge clk) begin
    if (!rst_n)
      hist <= '0;
    else if (upd_vld)
      hist <= {hist[HIST_W-2:0], upd_taken};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= 2'b10;
    end else if (upd_vld) begin
      if (agree && tbl[upd_idx] != 2'b11)
        tbl[upd_idx] <= tbl[upd_idx] + 2'b01;
      else if (!agree && tbl[upd_idx] != 2'b00)
        tbl[upd_idx] <= tbl[upd_idx] - 2'b01;
    end
  end
endmodule

module agree_gshare_pred_chk #(
  parameter int HIST_W = 10,
  parameter int PC_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   pred_pc,
  input logic [PC_W-1:0]   pred_target,
  input logic              pred_hint_vld,
  input logic              pred_static,
  input logic              upd_vld,
  input logic [HIST_W-1:0] upd_idx,
  input logic              upd_static,
  input logic              upd_taken,
  input logic [HIST_W-1:0] hist,
  input logic [1:0]        tbl [1 << HIST_W]
);
  // R2
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_vld |=> hist == {$past(hist[HIST_W-2:0]), $past(upd_taken)});
  // R2
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_vld |=> $stable(hist));
  // R4
  sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_vld && upd_taken == upd_static && tbl[upd_idx] == 2'b11)
      |=> tbl[$past(upd_idx)] == 2'b11);
  // R4
  sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_vld && upd_taken != upd_static && tbl[upd_idx] == 2'b00)
      |=> tbl[$past(upd_idx)] == 2'b00);
  // R5
  backward_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pred_hint_vld && pred_target < pred_pc) |-> pred_static);
  // R5
  forward_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pred_hint_vld && pred_target >= pred_pc) |-> !pred_static);
endmodule

bind agree_gshare_pred agree_gshare_pred_chk #(.HIST_W(HIST_W), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_target(pred_target),
  .pred_hint_vld(pred_hint_vld), .pred_static(pred_static), .upd_vld(upd_vld),
  .upd_idx(upd_idx), .upd_static(upd_static), .upd_taken(upd_taken),
  .hist(hist), .tbl(tbl)
);

// File: tb/tb_agree_gshare_pred.sv
module tb_agree_gshare_pred;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 10;
  localparam int PW = 32;
  localparam int MASK = (1 << HW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0] pred_pc = '0, pred_target = '0;
  logic pred_hint_vld = 1'b0, pred_hint = 1'b0;
  logic pred_dir, pred_static;
  logic [HW-1:0] pred_idx;
  logic upd_vld = 1'b0, upd_static = 1'b0, upd_taken = 1'b0;
  logic [HW-1:0] upd_idx = '0;

  int checks = 0, errors = 0;
  int m_tbl [0:MASK];
  int m_hist;

  always #(CLK_PERIOD/2) clk = ~clk;

  agree_gshare_pred #(.HIST_W(HW), .PC_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_target(pred_target),
    .pred_hint_vld(pred_hint_vld), .pred_hint(pred_hint), .pred_dir(pred_dir),
    .pred_static(pred_static), .pred_idx(pred_idx), .upd_vld(upd_vld),
    .upd_idx(upd_idx), .upd_static(upd_static), .upd_taken(upd_taken)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input string ph);
    int idx, st, dir;
    idx = ((pred_pc >> 2) & MASK) ^ m_hist;
    st  = pred_hint_vld ? int'(pred_hint) : int'(pred_target < pred_pc);
    dir = (m_tbl[idx] >= 2) ? st : 1 - st;
    chk({"R3 idx ", ph}, int'(pred_idx), idx);
    chk({"R5 static ", ph}, int'(pred_static), st);
    chk({"R6 dir ", ph}, int'(pred_dir), dir);
  endtask

  task automatic model_edge();
    if (upd_vld) begin
      if (upd_taken == upd_static) begin
        if (m_tbl[upd_idx] < 3) m_tbl[upd_idx]++;
      end else if (m_tbl[upd_idx] > 0) m_tbl[upd_idx]--;
      m_hist = ((m_hist << 1) | int'(upd_taken)) & MASK;
    end
  endtask

  task automatic step(input string ph, input logic [PW-1:0] pc, input logic [PW-1:0] tg,
                      input logic hv, input logic h, input logic uv,
                      input logic [HW-1:0] ui, input logic us, input logic ut);
    @(negedge clk);
    pred_pc = pc; pred_target = tg; pred_hint_vld = hv; pred_hint = h;
    upd_vld = uv; upd_idx = ui; upd_static = us; upd_taken = ut;
    #1 compare(ph);
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [HW-1:0] saved;
    logic [PW-1:0] pc;
    for (int i = 0; i <= MASK; i++) m_tbl[i] = 2;
    m_hist = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: after reset direction equals static guess, history zero
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      pc = 32'h1000 + 32'(i * 52);
      pred_pc = pc; pred_target = pc + 32'h40; pred_hint_vld = i[0]; pred_hint = i[1];
      upd_vld = 1'b0;
      #1;
      chk("R1 dir==static", int'(pred_dir), int'(pred_static));
      chk("R1 hist zero", int'(pred_idx), int'(pc[HW+1:2]));
    end

    // R4: drive one entry to 3 and hold, then to 0 and hold
    for (int i = 0; i < 5; i++) step("R4 up", 32'h0, 32'h4, 1'b0, 1'b0, 1'b1, 10'd5, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) step("R4 down", 32'h14, 32'h0, 1'b1, 1'b1, 1'b1, 10'd5, 1'b0, 1'b1);

    // R2: history observed through pred_idx with pc=0, holds without update
    for (int i = 0; i < 12; i++) step("R2 shift", 32'h0, 32'h8, 1'b0, 1'b0, 1'b1, 10'(i), 1'b0, i[0] ^ i[2]);
    for (int i = 0; i < 4; i++) step("R2 hold", 32'h0, 32'h8, 1'b0, 1'b0, 1'b0, 10'd0, 1'b0, 1'b1);

    // R7: stale captured index trains the original entry
    @(negedge clk);
    pred_pc = 32'h2468; upd_vld = 1'b0;
    #1 saved = pred_idx;
    @(posedge clk);
    for (int i = 0; i < 5; i++) step("R7 shift", 32'h2468, 32'h0, 1'b0, 1'b0, 1'b1, saved ^ 10'h3FF, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) step("R7 train", 32'h2468, 32'h0, 1'b0, 1'b0, 1'b1, saved, 1'b1, 1'b0);
    step("R7 check", 32'h2468, 32'h0, 1'b0, 1'b0, 1'b0, 10'd0, 1'b0, 1'b0);

    // R8: predict and update same entry in one cycle
    for (int i = 0; i < 20; i++) step("R8 same", 32'h400, 32'h100, 1'b0, 1'b0, 1'b1, pred_idx, 1'b1, i[1]);

    // random mix with small pc set to force aliasing
    for (int i = 0; i < 3000; i++) begin
      step("rand", 32'h3000 + 32'(($urandom % 64) * 4), 32'($urandom % 32'h6000),
           1'($urandom), 1'($urandom), 1'($urandom % 4 != 0),
           10'($urandom % 64), 1'($urandom), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule